// File: doc/BRIEF.md
# Destination Route Cache

This block keeps recently used forwarding decisions close to the packet path. A 32-bit IPv4 destination is folded into a line index; each line stores one route as a 64-bit word (the full destination as a tag plus the egress port, the link-layer address index and the flow class). When the stored tag equals the destination and the line is still valid, the route comes back one cycle after the lookup is accepted.

When the line does not match, the block holds the destination, stops accepting lookups and raises a request to an external agent that searches the full prefix table. The agent answers with a route for that exact destination, tagged with the table bank it read. That route is written into the line and returned to the requester. The prefix table behind the cache has two banks: one serves lookups while the other is rewritten. A swap command makes the other bank active and invalidates every line at once. A fill read from the bank that is no longer active is dropped, and the request stays up for the new bank.

Top module: `route_cache_top`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, miss_valid is 0 and active_bank is 0.
- R2: An accepted lookup whose line is valid and whose stored tag equals req_dst gives rsp_valid for one cycle in the cycle after acceptance, with rsp_hit=1 and the stored port, link index and flow.
- R3: An accepted lookup that does not hit raises miss_valid from the next cycle, with miss_dst equal to the destination and miss_bank equal to active_bank, held until a fill is taken.
- R4: A fill with fill_valid=1 and fill_bank equal to active_bank, while a miss is outstanding and no swap is commanded, writes the line and gives rsp_valid the next cycle with rsp_hit=0 and the fill fields; miss_valid drops and req_ready returns to 1.
- R5: The line index is the XOR of successive IDX_W-bit slices of the destination, the lowest slice at bit 0 and the top slice zero-extended. Two destinations with equal index but different value do not hit on each other's line; a fill for one replaces the other.
- R6: While a miss is outstanding, req_ready is 0, so a lookup held on the request port is neither accepted nor answered.
- R7: A cycle with swap_cmd=1 inverts active_bank from the next cycle.
- R8: After a swap, every line misses until filled again, and this still holds after the invalidation counter has wrapped (2**GEN_W swaps).
- R9: A fill whose fill_bank differs from active_bank, or which arrives in a cycle with swap_cmd=1, is dropped: no write, no response, and miss_valid stays 1 with miss_bank giving the current bank.
- R10: req_ready is 0 in any cycle in which swap_cmd is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup can be accepted this cycle |
| req_dst | input | 32 | Destination address to look up |
| rsp_valid | output | 1 | Result present (one cycle) |
| rsp_hit | output | 1 | 1 when the result came from a cached line |
| rsp_port | output | 8 | Egress interface |
| rsp_l2idx | output | 16 | Link-layer address index |
| rsp_flow | output | 8 | Flow class |
| miss_valid | output | 1 | Full-table search requested |
| miss_dst | output | 32 | Destination to search |
| miss_bank | output | 1 | Bank the search should read |
| fill_valid | input | 1 | Search result present |
| fill_bank | input | 1 | Bank the result was read from |
| fill_port | input | 8 | Result egress interface |
| fill_l2idx | input | 16 | Result link-layer address index |
| fill_flow | input | 8 | Result flow class |
| swap_cmd | input | 1 | Switch table bank and invalidate all lines |
| active_bank | output | 1 | Bank now serving lookups |

## Verification
Lookups are driven as first-touch misses followed by repeats, which separates the fill path from the hit path and shows the stored fields come back intact, including the all-zero and all-ones destinations. A pair of destinations that fold to one index shows that the full tag, not the index, decides a hit and that replacement works both ways. Swaps are mixed with outstanding misses and with fills from the old bank or in the swap cycle itself, telling a correct discard from a stale write, and a run of swaps past the counter wrap shows old lines stay dead. A lookup held on the port during a miss shows that back-pressure drops nothing and answers nothing twice.

// File: rtl/rc_pkg.sv
package rc_pkg;

    parameter int ADDR_W = 32;
    parameter int PORT_W = 8;
    parameter int L2_W   = 16;
    parameter int FLOW_W = 8;

    localparam int ROUTE_W = PORT_W + L2_W + FLOW_W;
    localparam int LINE_W  = ADDR_W + ROUTE_W;

    typedef struct packed {
        logic [PORT_W-1:0] port;
        logic [L2_W-1:0]   l2idx;
        logic [FLOW_W-1:0] flow;
    } route_t;

    typedef struct packed {
        logic [ADDR_W-1:0] tag;
        route_t            route;
    } line_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_MISS = 1'b1
    } state_e;

endpackage

// File: rtl/rc_hash.sv
module rc_hash
    import rc_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic [ADDR_W-1:0] dst,
    output logic [IDX_W-1:0]  idx
);
    localparam int SLICES = (ADDR_W + IDX_W - 1) / IDX_W;
    localparam int PAD_W  = SLICES * IDX_W;

    logic [PAD_W-1:0] padded;

    assign padded = PAD_W'(dst);

    always_comb begin
        idx = '0;
        for (int k = 0; k < SLICES; k++) begin
            idx = idx ^ padded[k*IDX_W +: IDX_W];
        end
    end
endmodule

// File: rtl/rc_line_store.sv
module rc_line_store
    import rc_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int GEN_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [ADDR_W-1:0] rd_tag,
    input  logic [GEN_W-1:0]  cur_gen,
    output logic              rd_hit,
    output route_t            rd_route,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  line_t             wr_line,
    input  logic              clr_all
);
    localparam int DEPTH = 1 << IDX_W;

    line_t              mem   [DEPTH];
    logic [GEN_W-1:0]   gen_q [DEPTH];
    logic [DEPTH-1:0]   vld_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx]   <= wr_line;
            gen_q[wr_idx] <= cur_gen;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else begin
            if (wr_en) begin
                vld_q[wr_idx] <= 1'b1;
            end
            if (clr_all) begin
                vld_q <= '0;
            end
        end
    end

    always_comb begin
        rd_route = mem[rd_idx].route;
        rd_hit   = vld_q[rd_idx]
                 && (gen_q[rd_idx] == cur_gen)
                 && (mem[rd_idx].tag == rd_tag);
    end
endmodule

// File: rtl/rc_ctrl.sv
module rc_ctrl
    import rc_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int GEN_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_dst,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic              rd_hit,
    input  route_t            rd_route,
    input  logic              fill_valid,
    input  logic              fill_bank,
    input  route_t            fill_route,
    input  logic              swap_cmd,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output route_t            rsp_route,
    output logic              miss_valid,
    output logic [ADDR_W-1:0] miss_dst,
    output logic              bank,
    output logic [GEN_W-1:0]  gen,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output line_t             wr_line,
    output logic              clr_all
);
    localparam logic [GEN_W-1:0] GEN_LAST = {GEN_W{1'b1}};

    state_e             state_q;
    logic [ADDR_W-1:0]  pend_dst_q;
    logic [IDX_W-1:0]   pend_idx_q;
    logic               bank_q;
    logic [GEN_W-1:0]   gen_q;
    logic               accept;
    logic               fill_ok;

    assign req_ready = (state_q == ST_IDLE) && !swap_cmd;
    assign accept    = req_valid && req_ready;
    assign fill_ok   = (state_q == ST_MISS) && fill_valid && !swap_cmd
                     && (fill_bank == bank_q);

    assign wr_en      = fill_ok;
    assign wr_idx     = pend_idx_q;
    assign wr_line    = '{tag: pend_dst_q, route: fill_route};
    assign clr_all    = swap_cmd && (gen_q == GEN_LAST);
    assign miss_valid = (state_q == ST_MISS);
    assign miss_dst   = pend_dst_q;
    assign bank       = bank_q;
    assign gen        = gen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            pend_dst_q <= '0;
            pend_idx_q <= '0;
            bank_q     <= 1'b0;
            gen_q      <= '0;
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_route  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (swap_cmd) begin
                bank_q <= ~bank_q;
                gen_q  <= gen_q + 1'b1;
            end
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        pend_dst_q <= req_dst;
                        pend_idx_q <= req_idx;
                        if (rd_hit) begin
                            rsp_valid <= 1'b1;
                            rsp_hit   <= 1'b1;
                            rsp_route <= rd_route;
                        end else begin
                            state_q <= ST_MISS;
                        end
                    end
                end
                ST_MISS: begin
                    if (fill_ok) begin
                        rsp_valid <= 1'b1;
                        rsp_hit   <= 1'b0;
                        rsp_route <= fill_route;
                        state_q   <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/route_cache_top.sv
module route_cache_top
    import rc_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int GEN_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_dst,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PORT_W-1:0] rsp_port,
    output logic [L2_W-1:0]   rsp_l2idx,
    output logic [FLOW_W-1:0] rsp_flow,
    output logic              miss_valid,
    output logic [ADDR_W-1:0] miss_dst,
    output logic              miss_bank,
    input  logic              fill_valid,
    input  logic              fill_bank,
    input  logic [PORT_W-1:0] fill_port,
    input  logic [L2_W-1:0]   fill_l2idx,
    input  logic [FLOW_W-1:0] fill_flow,
    input  logic              swap_cmd,
    output logic              active_bank
);
    logic [IDX_W-1:0] req_idx;
    logic             rd_hit;
    route_t           rd_route;
    route_t           fill_route;
    route_t           rsp_route;
    logic [GEN_W-1:0] gen;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    line_t            wr_line;
    logic             clr_all;
    logic             bank;

    assign fill_route  = '{port: fill_port, l2idx: fill_l2idx, flow: fill_flow};
    assign rsp_port    = rsp_route.port;
    assign rsp_l2idx   = rsp_route.l2idx;
    assign rsp_flow    = rsp_route.flow;
    assign miss_bank   = bank;
    assign active_bank = bank;

    rc_hash #(.IDX_W(IDX_W)) u_hash (
        .dst (req_dst),
        .idx (req_idx)
    );

    rc_line_store #(.IDX_W(IDX_W), .GEN_W(GEN_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (req_idx),
        .rd_tag   (req_dst),
        .cur_gen  (gen),
        .rd_hit   (rd_hit),
        .rd_route (rd_route),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_line  (wr_line),
        .clr_all  (clr_all)
    );

    rc_ctrl #(.IDX_W(IDX_W), .GEN_W(GEN_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_dst    (req_dst),
        .req_idx    (req_idx),
        .rd_hit     (rd_hit),
        .rd_route   (rd_route),
        .fill_valid (fill_valid),
        .fill_bank  (fill_bank),
        .fill_route (fill_route),
        .swap_cmd   (swap_cmd),
        .rsp_valid  (rsp_valid),
        .rsp_hit    (rsp_hit),
        .rsp_route  (rsp_route),
        .miss_valid (miss_valid),
        .miss_dst   (miss_dst),
        .bank       (bank),
        .gen        (gen),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_line    (wr_line),
        .clr_all    (clr_all)
    );
endmodule

// File: rtl/rc_checks.sv
module rc_checks (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic        miss_valid,
    input logic [31:0] miss_dst,
    input logic        fill_valid,
    input logic        fill_bank,
    input logic        swap_cmd,
    input logic        active_bank
);
    a_r6_no_accept_in_miss: assert property (@(posedge clk) disable iff (rst)
        miss_valid |-> !req_ready);

    a_r10_swap_blocks_lookup: assert property (@(posedge clk) disable iff (rst)
        swap_cmd |-> !req_ready);

    a_r7_swap_toggles_bank: assert property (@(posedge clk) disable iff (rst)
        swap_cmd |=> (active_bank != $past(active_bank)));

    a_r3_miss_dst_held: assert property (@(posedge clk) disable iff (rst)
        (miss_valid && $past(miss_valid)) |-> $stable(miss_dst));

    a_r4_rsp_has_cause: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($past(req_valid && req_ready) || $past(miss_valid && fill_valid)));

    a_r9_stale_fill_dropped: assert property (@(posedge clk) disable iff (rst)
        (miss_valid && fill_valid && (swap_cmd || (fill_bank != active_bank)))
        |=> (miss_valid && !rsp_valid));
endmodule

bind route_cache_top rc_checks u_checks (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .miss_valid  (miss_valid),
    .miss_dst    (miss_dst),
    .fill_valid  (fill_valid),
    .fill_bank   (fill_bank),
    .swap_cmd    (swap_cmd),
    .active_bank (active_bank)
);

// File: tb/route_cache_top_test.sv
module route_cache_top_test;
    localparam int IDX_W = 6;
    localparam int GEN_W = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_dst = '0;
    logic        rsp_valid, rsp_hit;
    logic [7:0]  rsp_port;
    logic [15:0] rsp_l2idx;
    logic [7:0]  rsp_flow;
    logic        miss_valid;
    logic [31:0] miss_dst;
    logic        miss_bank;
    logic        fill_valid = 1'b0;
    logic        fill_bank = 1'b0;
    logic [7:0]  fill_port = '0;
    logic [15:0] fill_l2idx = '0;
    logic [7:0]  fill_flow = '0;
    logic        swap_cmd = 1'b0;
    logic        active_bank;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit bk     = 0;
    logic [31:0] exp_route_q[$];
    bit          exp_hit_q[$];

    always #4 clk = ~clk;

    route_cache_top #(.IDX_W(IDX_W), .GEN_W(GEN_W)) uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_dst(req_dst),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_port(rsp_port),
        .rsp_l2idx(rsp_l2idx), .rsp_flow(rsp_flow),
        .miss_valid(miss_valid), .miss_dst(miss_dst), .miss_bank(miss_bank),
        .fill_valid(fill_valid), .fill_bank(fill_bank), .fill_port(fill_port),
        .fill_l2idx(fill_l2idx), .fill_flow(fill_flow),
        .swap_cmd(swap_cmd), .active_bank(active_bank)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_route(input logic [31:0] d, input bit b);
        logic [7:0]  p;
        logic [15:0] l;
        logic [7:0]  f;
        p = d[7:0] ^ {7'b0, b};
        l = d[15:0] ^ {16{b}};
        f = d[31:24] + {7'b0, b};
        return {p, l, f};
    endfunction

    // Scoreboard monitor: pops expected results as the design produces them
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_route_q.size() == 0) begin
                chk(1'b0, "R9", "unexpected response", 64'(rsp_hit), 64'd0);
            end else begin
                logic [31:0] er;
                bit eh;
                er = exp_route_q.pop_front();
                eh = exp_hit_q.pop_front();
                chk(rsp_hit == eh, eh ? "R2" : "R4", "rsp_hit", 64'(rsp_hit), 64'(eh));
                chk({rsp_port, rsp_l2idx, rsp_flow} == er, eh ? "R2" : "R4", "route",
                    64'({rsp_port, rsp_l2idx, rsp_flow}), 64'(er));
            end
        end
    end

    task automatic lookup(input logic [31:0] d, input bit hit, input bit rbank, input string req);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_dst   = d;
        if (hit) begin
            exp_route_q.push_back(model_route(d, rbank));
            exp_hit_q.push_back(1'b1);
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(miss_valid == !hit, req, "miss_valid after lookup", 64'(miss_valid), 64'(!hit));
        if (!hit) begin
            chk(miss_dst == d, "R3", "miss_dst", 64'(miss_dst), 64'(d));
            chk(miss_bank == bk, "R3", "miss_bank", 64'(miss_bank), 64'(bk));
            chk(!req_ready, "R6", "req_ready during miss", 64'(req_ready), 64'd0);
        end
    endtask

    task automatic fill(input logic [31:0] d, input bit fb, input bit take);
        fill_valid = 1'b1;
        fill_bank  = fb;
        {fill_port, fill_l2idx, fill_flow} = model_route(d, fb);
        if (take) begin
            exp_route_q.push_back(model_route(d, fb));
            exp_hit_q.push_back(1'b0);
        end
        @(negedge clk);
        fill_valid = 1'b0;
        chk(miss_valid == !take, take ? "R4" : "R9", "miss_valid after fill",
            64'(miss_valid), 64'(!take));
        chk(req_ready == take, take ? "R4" : "R6", "req_ready after fill",
            64'(req_ready), 64'(take));
    endtask

    task automatic miss_then_hit(input logic [31:0] d, input string req);
        lookup(d, 1'b0, 1'b0, req);
        fill(d, bk, 1'b1);
        lookup(d, 1'b1, bk, "R2");
    endtask

    task automatic do_swap();
        swap_cmd = 1'b1;
        #1;
        chk(!req_ready, "R10", "req_ready in swap cycle", 64'(req_ready), 64'd0);
        @(negedge clk);
        swap_cmd = 1'b0;
        bk = ~bk;
        chk(active_bank == bk, "R7", "active_bank", 64'(active_bank), 64'(bk));
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] a, b, g, h;
        a = 32'h0A00_0001;
        b = a ^ 32'h0000_0041;   // same folded index as a (R5)
        g = 32'h1234_5678;
        h = 32'h9ABC_DEF0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "req_ready", 64'(req_ready), 64'd1);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid", 64'(rsp_valid), 64'd0);
        chk(miss_valid == 1'b0, "R1", "miss_valid", 64'(miss_valid), 64'd0);
        chk(active_bank == 1'b0, "R1", "active_bank", 64'(active_bank), 64'd0);

        // Main function with several destinations, incl. all-zero / all-ones
        miss_then_hit(a, "R3");
        miss_then_hit(32'hC0A8_0164, "R3");
        miss_then_hit(32'hFFFF_FFFF, "R3");
        miss_then_hit(32'h0000_0000, "R3");
        lookup(a, 1'b1, 1'b0, "R2");

        // R5 index collision: tag decides, fill replaces
        lookup(b, 1'b0, 1'b0, "R5");
        fill(b, bk, 1'b1);
        lookup(a, 1'b0, 1'b0, "R5");
        fill(a, bk, 1'b1);
        lookup(b, 1'b0, 1'b0, "R5");
        fill(b, bk, 1'b1);
        lookup(b, 1'b1, bk, "R5");

        // R6 back-pressure: a held request is not taken during a miss
        lookup(32'h0102_0304, 1'b0, 1'b0, "R3");
        req_valid = 1'b1;
        req_dst   = 32'h0506_0708;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!req_ready, "R6", "req_ready held", 64'(req_ready), 64'd0);
            chk(miss_dst == 32'h0102_0304, "R6", "miss_dst held", 64'(miss_dst), 64'h01020304);
        end
        req_valid = 1'b0;
        fill(32'h0102_0304, bk, 1'b1);

        // R8 swap flushes lines
        do_swap();
        lookup(a, 1'b0, 1'b0, "R8");
        fill(a, bk, 1'b1);
        lookup(a, 1'b1, bk, "R2");
        lookup(32'hC0A8_0164, 1'b0, 1'b0, "R8");
        fill(32'hC0A8_0164, bk, 1'b1);

        // R9 fill from the old bank after a swap is dropped
        lookup(g, 1'b0, 1'b0, "R3");
        do_swap();
        chk(miss_valid == 1'b1, "R9", "miss kept over swap", 64'(miss_valid), 64'd1);
        chk(miss_bank == bk, "R9", "miss_bank after swap", 64'(miss_bank), 64'(bk));
        fill(g, ~bk, 1'b0);
        chk(miss_bank == bk, "R9", "miss_bank after drop", 64'(miss_bank), 64'(bk));
        fill(g, bk, 1'b1);
        lookup(g, 1'b1, bk, "R2");

        // R9 fill in the same cycle as a swap is dropped
        lookup(h, 1'b0, 1'b0, "R3");
        swap_cmd   = 1'b1;
        fill_valid = 1'b1;
        fill_bank  = bk;
        {fill_port, fill_l2idx, fill_flow} = model_route(h, bk);
        @(negedge clk);
        swap_cmd   = 1'b0;
        fill_valid = 1'b0;
        bk = ~bk;
        chk(miss_valid == 1'b1, "R9", "miss after swap+fill", 64'(miss_valid), 64'd1);
        fill(h, bk, 1'b1);
        lookup(h, 1'b1, bk, "R2");

        // R8 invalidation survives counter wrap
        lookup(g, 1'b0, 1'b0, "R8");
        fill(g, bk, 1'b1);
        for (int i = 0; i < (1 << GEN_W); i++) do_swap();
        lookup(g, 1'b0, 1'b0, "R8");
        fill(g, bk, 1'b1);
        lookup(g, 1'b1, bk, "R2");
        lookup(h, 1'b0, 1'b0, "R8");
        fill(h, bk, 1'b1);

        repeat (3) @(negedge clk);
        chk(exp_route_q.size() == 0, "R4", "responses outstanding",
            64'(exp_route_q.size()), 64'd0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule